// File: doc/BRIEF.md
# Hamming ECC spare-area packer

This block sits between a single-error-correcting parity engine and the spare-area buffer of a NAND page. For each 512-byte data chunk the engine delivers a 32-bit result word. The packer takes two 12-bit fields from that word and joins them into a 24-bit check code. It inverts the code so that an erased page, which reads back as all ones, checks clean. It then writes the three code bytes one at a time into a spare-area buffer.

A page-start pulse opens a page. It latches the page size and sets the first spare offset. Successive chunk codes follow one another with no gap in the spare area. After the page's last code has been written, a done flag rises. A result strobe that has no place to go is dropped and raises an overflow flag. The packer writes nothing outside the code bytes, so spare bytes the caller left at 0xFF stay at 0xFF.

Top module: `ecc_oob_packer`

## Requirements
- R1: A synchronous active-low reset leaves `wr_en`, `done` and `overflow` low.
- R2: The check code is the bitwise inverse of {result[27:16], result[11:0]}. Result bits 31:28 and 15:12 have no effect on any written byte.
- R3: An accepted code is written in three consecutive cycles, starting the cycle after acceptance. The least significant byte goes first, and the offset rises by one with each byte.
- R4: `page_sel` is latched at page start and is encoded 0 = 512-byte, 1 = 2048-byte, 2 = 4096-byte and 3 = 8192-byte page. The first code byte of the page goes to offset 0, 40, 80 and 80 respectively.
- R5: The code for chunk k of a page starts at the first offset plus 3k. A strobe presented in the cycle of the previous code's last byte is accepted, so writes can run back to back.
- R6: `done` rises in the cycle after the last byte of code number page_bytes/512 (1, 4, 8 or 16). It then stays high until the next page start.
- R7: No write reaches any offset outside the page's code region of 3 × page_bytes/512 bytes.
- R8: A strobe is ignored, with no write and no chunk counted, and `overflow` is set, in three cases: when no page is open (after reset, or once `done` is set, including a strobe in the final byte's cycle), or while a code is still being written and is not in its last byte. `overflow` holds until the next page start clears it.
- R9: A page start abandons any code being written and clears `done` and `overflow`. A strobe in the same cycle becomes chunk 0 of the new page, and its first byte goes to the new first offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_start | input | 1 | Opens a new page; latches `page_sel` |
| page_sel | input | 2 | Page size code (0:512, 1:2048, 2:4096, 3:8192 bytes) |
| res_valid | input | 1 | Result word strobe, one per data chunk |
| res_word | input | 32 | Parity engine result word |
| wr_en | output | 1 | Spare-buffer byte write enable |
| wr_off | output | 8 | Spare-buffer byte offset |
| wr_byte | output | 8 | Byte value to write |
| done | output | 1 | All codes of the page have been written |
| overflow | output | 1 | A result strobe was dropped since the last page start |

## Verification
Two events can fall on the same clock edge. A result strobe can meet the last byte of the previous code, and a page start can meet both a strobe and a code still being written. To provoke the first, the bench presents the next strobe exactly three cycles after the one before. Inside a page this must give contiguous offsets; on the final chunk the same timing must give done together with overflow and no extra write. To provoke the second, the bench raises page start together with a new strobe one cycle into a code. It then judges that the next write lands at the new page's first offset with the new code's low byte.

// File: rtl/ecc_oob_pkg.sv
// Package: shared constants and the page size encoding for the spare-area
// ECC packer. Assumes one check code per 512-byte data chunk.
package ecc_oob_pkg;
    localparam int CHUNK_BYTES  = 512;
    localparam int SEL_W        = 2;
    localparam int WORD_W       = 32;
    localparam int HALF_W       = 12;
    localparam int HI_LSB       = 16;
    localparam int OFF_W        = 8;
    localparam int MAX_CHUNKS   = 8192 / CHUNK_BYTES;
    localparam int CNT_W        = $clog2(MAX_CHUNKS + 1);

    typedef enum logic [SEL_W-1:0] {
        PG_512  = 2'd0,
        PG_2K   = 2'd1,
        PG_4K   = 2'd2,
        PG_8K   = 2'd3
    } pg_size_e;
endpackage

// File: rtl/ecc_code_fmt.sv
// Module: ecc_code_fmt
// Joins the two significant halves of a parity result into one check code and
// inverts it, so that an all-ones (erased) page carries a matching code.
// Assumes the halves sit at [HALF_W-1:0] and [HI_LSB +: HALF_W].
module ecc_code_fmt #(
    parameter int HALF_W = 12
) (
    input  logic [HALF_W-1:0]   lo_half,
    input  logic [HALF_W-1:0]   hi_half,
    output logic [2*HALF_W-1:0] code
);
    // Concatenate and invert the halves.
    always_comb begin
        code = ~{hi_half, lo_half};
    end
endmodule

// File: rtl/oob_layout.sv
// Module: oob_layout
// Maps the page size code to the first spare offset and the number of chunk
// codes per page. Assumes the 2-bit encoding of ecc_oob_pkg::pg_size_e.
module oob_layout
    import ecc_oob_pkg::*;
#(
    parameter int OFF_W       = 8,
    parameter int CNT_W       = 5,
    parameter int START_SMALL = 0,
    parameter int START_MID   = 40,
    parameter int START_BIG   = 80
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OFF_W-1:0] start_off,
    output logic [CNT_W-1:0] n_chunks
);
    // Decode page size into layout constants.
    always_comb begin
        unique case (pg_size_e'(sel))
            PG_512: begin
                start_off = OFF_W'(START_SMALL);
                n_chunks  = CNT_W'(512 / CHUNK_BYTES);
            end
            PG_2K: begin
                start_off = OFF_W'(START_MID);
                n_chunks  = CNT_W'(2048 / CHUNK_BYTES);
            end
            PG_4K: begin
                start_off = OFF_W'(START_BIG);
                n_chunks  = CNT_W'(4096 / CHUNK_BYTES);
            end
            default: begin
                start_off = OFF_W'(START_BIG);
                n_chunks  = CNT_W'(8192 / CHUNK_BYTES);
            end
        endcase
    end
endmodule

// File: rtl/oob_byte_emitter.sv
// Module: oob_byte_emitter
// Serialises a multi-byte code into byte writes, least significant first,
// at a running offset. A load may coincide with the last byte of the previous
// code; abort drops a code in flight. Assumes load has priority over abort.
module oob_byte_emitter #(
    parameter int CODE_BYTES = 3,
    parameter int OFF_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    set_off,
    input  logic [OFF_W-1:0]        start_off,
    input  logic                    abort,
    input  logic                    load,
    input  logic [8*CODE_BYTES-1:0] code,
    output logic                    wr_en,
    output logic [OFF_W-1:0]        wr_off,
    output logic [7:0]              wr_byte,
    output logic                    last_byte
);
    localparam int CODE_W = 8 * CODE_BYTES;
    localparam int IDX_W  = (CODE_BYTES > 1) ? $clog2(CODE_BYTES) : 1;

    logic              active;
    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] sh;
    logic [OFF_W-1:0]  off;

    assign last_byte = active && (idx == IDX_W'(CODE_BYTES - 1));

    // Running spare offset: reloaded at page start, bumped per written byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off <= '0;
        end else if (set_off) begin
            off <= start_off;
        end else if (active) begin
            off <= off + OFF_W'(1);
        end
    end

    // Byte sequencer: load a code, shift out one byte per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            idx    <= '0;
            sh     <= '0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
            sh     <= code;
        end else if (abort) begin
            active <= 1'b0;
        end else if (active) begin
            sh  <= sh >> 8;
            idx <= idx + IDX_W'(1);
            if (last_byte) begin
                active <= 1'b0;
            end
        end
    end

    assign wr_en   = active;
    assign wr_off  = off;
    assign wr_byte = sh[7:0];
endmodule

// File: rtl/ecc_oob_packer.sv
// Module: ecc_oob_packer (top)
// Turns per-chunk parity results into inverted 24-bit codes and writes them
// into a spare-area buffer at page-size dependent offsets. Tracks chunks per
// page, flags completion and dropped strobes. Assumes the buffer was preset to
// 0xFF by its owner; only code bytes are written.
module ecc_oob_packer
    import ecc_oob_pkg::*;
#(
    parameter int P_WORD_W      = WORD_W,
    parameter int P_HALF_W      = HALF_W,
    parameter int P_HI_LSB      = HI_LSB,
    parameter int P_OFF_W       = OFF_W,
    parameter int P_CNT_W       = CNT_W,
    parameter int P_START_SMALL = 0,
    parameter int P_START_MID   = 40,
    parameter int P_START_BIG   = 80
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  page_start,
    input  logic [SEL_W-1:0]      page_sel,
    input  logic                  res_valid,
    input  logic [P_WORD_W-1:0]   res_word,
    output logic                  wr_en,
    output logic [P_OFF_W-1:0]    wr_off,
    output logic [7:0]            wr_byte,
    output logic                  done,
    output logic                  overflow
);
    localparam int CODE_W     = 2 * P_HALF_W;
    localparam int CODE_BYTES = CODE_W / 8;

    logic [CODE_W-1:0]    fmt_code;
    logic [P_OFF_W-1:0]   lay_start;
    logic [P_CNT_W-1:0]   lay_n;
    logic [P_CNT_W-1:0]   n_lat;
    logic [P_CNT_W-1:0]   cnt;
    logic                 page_open;
    logic                 done_q;
    logic                 ovf_q;
    logic                 busy;
    logic                 last_byte;
    logic                 final_chunk;
    logic                 closing;
    logic                 room;
    logic                 accept;
    logic                 unused_bits;

    // Result bits outside the two halves carry nothing for the code.
    assign unused_bits = ^{res_word[P_WORD_W-1:P_HI_LSB+P_HALF_W],
                           res_word[P_HI_LSB-1:P_HALF_W]};

    ecc_code_fmt #(.HALF_W(P_HALF_W)) u_fmt (
        .lo_half (res_word[P_HALF_W-1:0]),
        .hi_half (res_word[P_HI_LSB +: P_HALF_W]),
        .code    (fmt_code)
    );

    oob_layout #(
        .OFF_W       (P_OFF_W),
        .CNT_W       (P_CNT_W),
        .START_SMALL (P_START_SMALL),
        .START_MID   (P_START_MID),
        .START_BIG   (P_START_BIG)
    ) u_layout (
        .sel       (page_sel),
        .start_off (lay_start),
        .n_chunks  (lay_n)
    );

    // Acceptance: a page start always takes the strobe; otherwise the page
    // must be open, not closing, and the emitter free or on its last byte.
    always_comb begin
        final_chunk = (cnt == n_lat - P_CNT_W'(1));
        closing     = last_byte && final_chunk;
        room        = page_open && !closing && (!busy || last_byte);
        accept      = res_valid && (page_start || room);
    end

    oob_byte_emitter #(
        .CODE_BYTES (CODE_BYTES),
        .OFF_W      (P_OFF_W)
    ) u_emit (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_off   (page_start),
        .start_off (lay_start),
        .abort     (page_start),
        .load      (accept),
        .code      (fmt_code),
        .wr_en     (busy),
        .wr_off    (wr_off),
        .wr_byte   (wr_byte),
        .last_byte (last_byte)
    );

    // Page bookkeeping: chunk count, open/done state and dropped strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_lat     <= P_CNT_W'(1);
            cnt       <= '0;
            page_open <= 1'b0;
            done_q    <= 1'b0;
            ovf_q     <= 1'b0;
        end else if (page_start) begin
            n_lat     <= lay_n;
            cnt       <= '0;
            page_open <= 1'b1;
            done_q    <= 1'b0;
            ovf_q     <= 1'b0;
        end else begin
            if (last_byte) begin
                cnt <= cnt + P_CNT_W'(1);
                if (final_chunk) begin
                    page_open <= 1'b0;
                    done_q    <= 1'b1;
                end
            end
            if (res_valid && !room) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign wr_en    = busy;
    assign done     = done_q;
    assign overflow = ovf_q;
endmodule

// File: rtl/ecc_oob_packer_chk.sv
// Module: ecc_oob_packer_chk
// Port-level temporal checks for ecc_oob_packer, bound to every instance.
module ecc_oob_packer_chk #(
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             page_start,
    input logic             wr_en,
    input logic [OFF_W-1:0] wr_off,
    input logic             done,
    input logic             overflow
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!wr_en && !done && !overflow));

    // R3
    byte_stride_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !page_start) |=> (!wr_en || wr_off == OFF_W'($past(wr_off) + OFF_W'(1))));

    // R6
    done_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(wr_en));

    // R8
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !page_start) |=> !wr_en);

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !page_start) |=> overflow);

    // R9
    page_start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (!done && !overflow));
endmodule

bind ecc_oob_packer ecc_oob_packer_chk #(.OFF_W(P_OFF_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_start (page_start),
    .wr_en      (wr_en),
    .wr_off     (wr_off),
    .done       (done),
    .overflow   (overflow)
);

// File: tb/sim_ecc_oob_packer.sv
`timescale 1ns/1ps
// Bench: sweeps every page size with two strobe spacings, then drives the
// collision and drop cases. Expected bytes are derived from the requirements.
module sim_ecc_oob_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_start = 1'b0;
    logic [1:0]  page_sel = 2'd0;
    logic        res_valid = 1'b0;
    logic [31:0] res_word = 32'h0;
    logic        wr_en;
    logic [7:0]  wr_off;
    logic [7:0]  wr_byte;
    logic        done;
    logic        overflow;

    int checks = 0;
    int fails = 0;
    int wcount = 0;
    int cyc = 0;
    logic [7:0] spare [0:255];

    ecc_oob_packer u0 (
        .clk(clk), .rst_n(rst_n), .page_start(page_start), .page_sel(page_sel),
        .res_valid(res_valid), .res_word(res_word), .wr_en(wr_en),
        .wr_off(wr_off), .wr_byte(wr_byte), .done(done), .overflow(overflow)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Buffer model: capture every write away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            spare[wr_off] = wr_byte;
            wcount++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] expc(input logic [31:0] w);
        return ~{w[27:16], w[11:0]};
    endfunction

    function automatic int first_off(input int s);
        return (s == 0) ? 0 : (s == 1) ? 40 : 80;
    endfunction

    function automatic int nchunk(input int s);
        return (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 16;
    endfunction

    function automatic logic [31:0] pat(input int k, input int s);
        return (32'h9E37_79B9 * (k + 3)) ^ (32'(s) << 28) ^ (32'(k) << 13);
    endfunction

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic clear_buf;
        for (int i = 0; i < 256; i++) spare[i] = 8'hFF;
        wcount = 0;
    endtask

    task automatic open_page(input int s, input bit with_w, input logic [31:0] w);
        page_start = 1'b1;
        page_sel   = 2'(s);
        res_valid  = with_w;
        res_word   = w;
        tick();
        page_start = 1'b0;
        res_valid  = 1'b0;
    endtask

    task automatic strobe(input logic [31:0] w);
        res_valid = 1'b1;
        res_word  = w;
        tick();
        res_valid = 1'b0;
    endtask

    initial begin
        clear_buf();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(!wr_en, "R1 wr_en", wr_en, 0);
        chk(!done, "R1 done", done, 0);
        chk(!overflow, "R1 overflow", overflow, 0);

        // R8: strobe before any page is opened
        strobe(32'h1234_5678);
        chk(!wr_en, "R8 no write before page", wr_en, 0);
        chk(overflow, "R8 overflow before page", overflow, 1);

        // R2 R3 R4 R6: directed byte timing, 512-byte page
        open_page(0, 1'b0, 0);
        chk(!overflow, "R9 overflow cleared", overflow, 0);
        strobe(32'hA5C3_F0E1);
        begin
            logic [23:0] c;
            c = expc(32'hA5C3_F0E1);
            chk(wr_en && wr_off == 8'd0 && wr_byte == c[7:0], "R3 byte0", {wr_off, wr_byte}, {8'd0, c[7:0]});
            tick();
            chk(wr_en && wr_off == 8'd1 && wr_byte == c[15:8], "R3 byte1", {wr_off, wr_byte}, {8'd1, c[15:8]});
            chk(!done, "R6 not yet done", done, 0);
            tick();
            chk(wr_en && wr_off == 8'd2 && wr_byte == c[23:16], "R3 byte2", {wr_off, wr_byte}, {8'd2, c[23:16]});
            chk(!done, "R6 not done on last byte", done, 0);
            tick();
            chk(!wr_en && done, "R6 done after last byte", {wr_en, done}, 2'b01);
        end

        // R2: ignored bits and all-ones/all-zeros halves
        open_page(1, 1'b0, 0);
        strobe(32'hF000_F000);
        chk(wr_byte == 8'hFF && wr_off == 8'd40, "R2 zero halves give FF", wr_byte, 8'hFF);
        tick(); tick();
        strobe(32'h0FFF_0FFF);
        chk(wr_byte == 8'h00 && wr_off == 8'd43, "R2 ones halves give 00", wr_byte, 8'h00);
        tick(); tick();
        strobe(32'h0000_0000);
        chk(wr_byte == 8'hFF, "R2 high nibbles ignored", wr_byte, 8'hFF);

        // R4 R5 R6 R7 R2: sweep page sizes and strobe spacings
        for (int s = 0; s < 4; s++) begin
            for (int g = 2; g <= 4; g += 2) begin
                open_page(s, 1'b0, 0);
                tick();
                clear_buf();
                for (int k = 0; k < nchunk(s); k++) begin
                    strobe(pat(k, s));
                    repeat (g) tick();
                end
                repeat (3) tick();
                #1;
                chk(done, "R6 done after page", done, 1);
                chk(!overflow, "R5 no drop at spacing", overflow, 0);
                chk(wcount == 3 * nchunk(s), "R7 write count", wcount, 3 * nchunk(s));
                for (int o = 0; o < 256; o++) begin
                    logic [7:0] e;
                    int st;
                    st = first_off(s);
                    e = 8'hFF;
                    if (o >= st && o < st + 3 * nchunk(s)) begin
                        logic [23:0] c;
                        c = expc(pat((o - st) / 3, s));
                        e = 8'(c >> (8 * ((o - st) % 3)));
                    end
                    chk(spare[o] == e, "R5 R7 spare byte", {o[7:0], spare[o]}, {o[7:0], e});
                end
                // R8: strobe after done is dropped
                strobe(32'hDEAD_BEEF);
                chk(!wr_en && done && overflow, "R8 strobe after done", {wr_en, done, overflow}, 3'b011);
                repeat (3) tick();
                #1;
                chk(wcount == 3 * nchunk(s), "R8 no write after done", wcount, 3 * nchunk(s));
            end
        end

        // R8 R6: strobe in the final byte cycle of the last chunk
        open_page(0, 1'b0, 0);
        strobe(32'h0101_0202);
        tick(); tick();
        strobe(32'h0303_0404);
        chk(!wr_en && done && overflow, "R8 strobe on final byte", {wr_en, done, overflow}, 3'b011);

        // R8: strobe in the middle of a code is dropped
        open_page(1, 1'b0, 0);
        strobe(32'h0ABC_0DEF);
        strobe(32'h0111_0222);
        begin
            logic [23:0] c;
            c = expc(32'h0ABC_0DEF);
            chk(overflow && wr_off == 8'd41 && wr_byte == c[15:8], "R8 mid-code strobe",
                {overflow, wr_off, wr_byte}, {1'b1, 8'd41, c[15:8]});
        end

        // R9: page start with a strobe while a code is in flight
        open_page(1, 1'b0, 0);
        strobe(32'h0555_0666);
        open_page(2, 1'b1, 32'h0777_0888);
        begin
            logic [23:0] c;
            c = expc(32'h0777_0888);
            chk(wr_en && wr_off == 8'd80 && wr_byte == c[7:0] && !overflow, "R9 abort and new chunk0",
                {overflow, wr_off, wr_byte}, {1'b0, 8'd80, c[7:0]});
            tick(); tick();
            for (int k = 1; k < 8; k++) begin
                strobe(pat(k, 7));
                tick(); tick();
            end
            tick();
            chk(done && !overflow, "R9 new page completes", {done, overflow}, 2'b10);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule